// File: doc/BRIEF.md
# Phase Accumulator Oscillator

This block is a numerically controlled oscillator. A 20-bit accumulator adds a programmable 20-bit increment on every clock while the block is running. The carry out of that addition is the overflow event. With a clock of frequency f and an increment k, overflow events happen at f·k/2^20 on average. At 16 MHz, an increment of about 16711 (0x4147) gives roughly 255 kHz.

Software drives the block through four byte-wide write strobes that share one data bus. A control write sets the run enable and the output mode. Three increment writes load the upper, high and low fields. The accumulator is always visible on an output port. When the block is stopped, the accumulator holds its value, so it can act as an event counter read after a gated interval.

In fixed-duty mode the output toggles on each overflow, giving a 50% square wave at half the overflow rate. In pulse mode the output is high for one clock on each overflow.

Top module: `phase_osc`

## Requirements
- R1: Reset clears the accumulator, the output, the run enable, the output mode (to fixed-duty), the staged increment bytes and the active increment.
- R2: On each clock edge where the run enable is set, the accumulator becomes (accumulator + active increment) mod 2^20.
- R3: On each clock edge where the run enable is clear, the accumulator keeps its value.
- R4: In fixed-duty mode (control bit 0 = 0), the output inverts on exactly those edges where the addition produces a carry out of bit 19, and it is otherwise unchanged. This includes edges where the block is stopped.
- R5: In pulse mode (control bit 0 = 1), the output is high during the clock after each carry-producing edge and low otherwise. This includes the clocks after the block is stopped.
- R6: A write with `wr_ctl` high sets the run enable from `wr_data[7]` and the mode from `wr_data[0]`. Bits 6 to 1 have no effect.
- R7: `wr_up` stages `wr_data[3:0]` as increment bits 19:16, and `wr_data[7:4]` is ignored. `wr_hi` stages bits 15:8. `wr_lo` supplies bits 7:0.
- R8: The active increment changes only on a `wr_lo` write, which commits the two staged fields together with the low byte. Writes to the upper or high field alone leave the count rate unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_ctl | input | 1 | Control write strobe |
| wr_up | input | 1 | Upper increment field write strobe |
| wr_hi | input | 1 | High increment field write strobe |
| wr_lo | input | 1 | Low increment field write strobe (commits) |
| wr_data | input | 8 | Write data shared by all strobes |
| acc_q | output | 20 | Accumulator value |
| osc_out | output | 1 | Oscillator output |

## Verification
The assertions assume that at most one write strobe is high in any cycle. The checker includes a property for this assumption, and every bench task raises a single strobe for one cycle and then clears it before the next write. The pulse-mode property relates the output to the accumulator being below the increment. It therefore applies only in cycles where the mode and increment were already stable on the previous edge. The stimulus changes the mode only through a control write that precedes the counting window.

// File: rtl/phase_osc.sv
module phase_osc #(
  parameter int ACC_W    = 20,
  parameter int BYTE_W   = 8,
  parameter int EN_BIT   = 7,
  parameter int MODE_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic              wr_up,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [ACC_W-1:0]  acc_q,
  output logic              osc_out
);
  localparam int UP_W = ACC_W - 2*BYTE_W;

  logic              run_q;
  logic              pulse_mode_q;
  logic [UP_W-1:0]   up_stg_q;
  logic [BYTE_W-1:0] hi_stg_q;
  logic [ACC_W-1:0]  inc_q;
  logic [ACC_W-1:0]  acc_r;
  logic              out_r;
  logic [ACC_W:0]    sum;
  logic              carry;

  assign sum     = {1'b0, acc_r} + {1'b0, inc_q};
  assign carry   = run_q & sum[ACC_W];
  assign acc_q   = acc_r;
  assign osc_out = out_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q        <= 1'b0;
      pulse_mode_q <= 1'b0;
    end else if (wr_ctl) begin
      run_q        <= wr_data[EN_BIT];
      pulse_mode_q <= wr_data[MODE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_stg_q <= '0;
      hi_stg_q <= '0;
      inc_q    <= '0;
    end else begin
      if (wr_up) up_stg_q <= wr_data[UP_W-1:0];
      if (wr_hi) hi_stg_q <= wr_data;
      if (wr_lo) inc_q    <= {up_stg_q, hi_stg_q, wr_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_r <= '0;
      out_r <= 1'b0;
    end else begin
      if (run_q) acc_r <= sum[ACC_W-1:0];
      if (pulse_mode_q) out_r <= carry;
      else if (carry)   out_r <= ~out_r;
    end
  end
endmodule

// File: rtl/phase_osc_chk.sv
module phase_osc_chk #(
  parameter int ACC_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_ctl,
  input logic             wr_up,
  input logic             wr_hi,
  input logic             wr_lo,
  input logic             run_q,
  input logic             pulse_mode_q,
  input logic [ACC_W-1:0] inc_q,
  input logic [ACC_W-1:0] acc_q,
  input logic             osc_out
);
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ctl, wr_up, wr_hi, wr_lo}));

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (acc_q == '0 && !osc_out && !run_q && inc_q == '0));

  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(acc_q));

  // R4
  fdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !pulse_mode_q) |=> $stable(osc_out));

  // R5
  pfm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && pulse_mode_q) |=> !osc_out);

  // R5
  pfm_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode_q && $past(pulse_mode_q) && $stable(inc_q) && osc_out) |-> (acc_q < inc_q));

  // R8
  commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo |=> $stable(inc_q));
endmodule

bind phase_osc phase_osc_chk #(.ACC_W(ACC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_up(wr_up), .wr_hi(wr_hi),
  .wr_lo(wr_lo), .run_q(run_q), .pulse_mode_q(pulse_mode_q), .inc_q(inc_q),
  .acc_q(acc_q), .osc_out(osc_out)
);

// File: tb/phase_osc_tb_top.sv
module phase_osc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_ctl = 1'b0, wr_up = 1'b0, wr_hi = 1'b0, wr_lo = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [19:0] acc_q;
  logic        osc_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  longint acc_m = 0;
  longint inc_m = 0;

  // {mode, cycles[10:0], increment[19:0]}
  localparam logic [31:0] VEC [8] = '{
    {1'b0, 11'd10,  20'h00001},
    {1'b0, 11'd200, 20'h04147},
    {1'b1, 11'd200, 20'h04147},
    {1'b1, 11'd5,   20'hFFFFF},
    {1'b0, 11'd6,   20'h80000},
    {1'b0, 11'd20,  20'h00000},
    {1'b1, 11'd100, 20'h12345},
    {1'b0, 11'd300, 20'h0828F}
  };

  always #4 clk = ~clk;

  phase_osc dut_i (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_up(wr_up), .wr_hi(wr_hi),
    .wr_lo(wr_lo), .wr_data(wr_data), .acc_q(acc_q), .osc_out(osc_out)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int sel, logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    case (sel)
      0: wr_ctl = 1'b1;
      1: wr_up  = 1'b1;
      2: wr_hi  = 1'b1;
      default: wr_lo = 1'b1;
    endcase
    @(negedge clk);
    {wr_ctl, wr_up, wr_hi, wr_lo} = '0;
  endtask

  task automatic load_inc(logic [19:0] v);
    wr(1, {4'hA, v[19:16]});
    wr(2, v[15:8]);
    wr(3, v[7:0]);
    inc_m = v;
  endtask

  task automatic run(int n, bit pm, string req);
    int pulses = 0;
    int flips = 0;
    logic prev;
    longint total;
    @(negedge clk);
    wr_ctl = 1'b1;
    wr_data = {1'b1, 6'h2A, pm};
    @(negedge clk);
    wr_ctl = 1'b0;
    prev = osc_out;
    for (int i = 1; i <= n; i++) begin
      if (i == n) begin
        wr_ctl = 1'b1;
        wr_data = {1'b0, 6'h15, pm};
      end
      @(negedge clk);
      if (i == n) wr_ctl = 1'b0;
      pulses += int'(osc_out);
      if (osc_out != prev) flips++;
      prev = osc_out;
    end
    total = acc_m + longint'(n) * inc_m;
    acc_m = total % (64'd1 << 20);
    // R2
    check(acc_q == acc_m[19:0], {req, " R2 acc"}, acc_q, acc_m);
    if (pm) check(pulses == (total >> 20), {req, " R5 pulses"}, pulses, total >> 20);
    else    check(flips  == (total >> 20), {req, " R4 toggles"}, flips, total >> 20);
    repeat (5) @(negedge clk);
    // R3
    check(acc_q == acc_m[19:0], {req, " R3 hold"}, acc_q, acc_m);
    if (pm) check(osc_out == 1'b0, {req, " R5 idle low"}, osc_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(acc_q == 0, "R1 acc", acc_q, 0);
    check(osc_out == 0, "R1 out", osc_out, 0);
    rst_n = 1'b1;

    for (int v = 0; v < 8; v++) begin
      load_inc(VEC[v][19:0]);
      run(int'(VEC[v][30:20]), VEC[v][31], $sformatf("R7 vec%0d", v));
    end

    // R8: upper and high writes alone do not change the rate
    wr(1, 8'h07);
    wr(2, 8'hFF);
    run(10, 1'b0, "R8 staged");
    wr(3, 8'h00);
    inc_m = 20'h7FF00;
    run(4, 1'b0, "R8 committed");

    // R6: control bits 6..1 alone do not start the block
    wr(0, 8'h7E);
    repeat (4) @(negedge clk);
    check(acc_q == acc_m[19:0], "R6 ignored bits", acc_q, acc_m);

    // R1: mid-run reset clears state and enable
    load_inc(20'h40000);
    wr(0, 8'h80);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    acc_m = 0;
    check(acc_q == 0 && osc_out == 0, "R1 mid reset", acc_q, 0);
    wr(1, 8'h01);
    wr(2, 8'h00);
    wr(3, 8'h00);
    inc_m = 20'h10000;
    repeat (6) @(negedge clk);
    check(acc_q == 0, "R1 enable cleared", acc_q, 0);
    run(40, 1'b0, "R1 after reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule